// File: doc/BRIEF.md
# Instruction Cache Debug State Walker

This block sits beside a set-associative instruction cache and lets a bus master look at the cache's internal bookkeeping one entry at a time. A mode bit puts the cache into a debug state. In that state the fill, valid and replacement updates are frozen, so the contents stay fixed while they are being read. The cache arrays here are a plain register model with a single update port. That port stands in for the normal fill and replacement traffic.

Three read-only state windows are provided: line tag, line valid bit and per-index replacement bits. Each window has its own walk counter. The low bits of the counter pick the index and the high bits pick the way. An initialization command clears all three counters and loads each window with the entry at way 0, index 0. Each read of a window returns the snapshot it currently holds. On the next cycle that window alone steps to the next entry. Reading the same address again and again therefore walks the whole cache.

The debug state can be left only when every attached core reports that it is itself in debug. A per-core status vector carries these reports.

Top module: `icache_dbg_walker`

## Requirements
- R1: Writing the mode register (word address 1) with bit 0 set enters debug mode on the next cycle. Reading address 1 returns the mode in bit 0 and zero in the other bits.
- R2: While debug mode is active, the cache update port changes no tag, valid or replacement entry.
- R3: Writing the mode register with bit 0 clear leaves debug mode only when every bit of `core_dbg_sts` is set. Otherwise the write is ignored.
- R4: Writing the command register (word address 0) sets the command code from bits 8:0 and a one-cycle go flag from bit 31. When the go flag is set and the code is 0x100, all three counters become 0 and each window loads way 0, index 0. The command code reads back at address 0, in bits 8:0.
- R5: A read of a window at address 2 (tag), 3 (valid) or 4 (replacement) in debug mode returns the current snapshot. From the next cycle the window holds the following entry, so back-to-back reads return consecutive entries.
- R6: A read of one window leaves the counters and snapshots of the other two windows unchanged.
- R7: Counter bits 4:0 select the index and bits 6:5 select the way. The walk runs index 0 to 31 of way 0, then of way 1, and so on. After way 3, index 31, it wraps to way 0, index 0.
- R8: Outside debug mode, window addresses read as zero, and reading them does not advance any counter.
- R9: A go flag with any command code other than 0x100 changes no counter. The go flag clears itself after one cycle.
- R10: The tag window returns the 20-bit tag in bits 19:0. The valid window returns the line valid bit in bit 0. The replacement window returns the 3 replacement bits of the addressed index in bits 2:0, independent of the way. All other bits are zero.
- R11: After reset, debug mode is off, the command code is 0, and every window, counter and cache entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_dbg_sts | input | NCORES | Per-core "in debug" status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dbg_mode | output | 1 | Debug mode active |
| upd_en | input | 1 | Cache update strobe (normal operation) |
| upd_way | input | log2(WAYS) | Way to update |
| upd_idx | input | log2(SETS) | Index to update |
| upd_tag | input | TAG_W | Tag value to store |
| upd_valid | input | 1 | Valid bit to store |
| upd_lrm | input | LRM_W | Replacement bits to store for the index |

## Verification
The assertions assume that the master never raises `bus_wr` and `bus_rd` in the same cycle. They also assume that all inputs settle well away from the rising edge. The stimulus keeps to this by driving one operation per cycle on the falling edge. The counter-hold properties assume that a window advances only by a read of its own address, and the bench reads each window separately or interleaves single reads. The stimulus covers a full wrap of the tag walk and update attempts during debug mode. It also covers clear attempts with an incomplete core-status vector and a go flag with a wrong command code.

// File: rtl/icd_pkg.sv
package icd_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CMD   = 3'd0,
        RA_MODE  = 3'd1,
        RA_TAG   = 3'd2,
        RA_VALID = 3'd3,
        RA_LRM   = 3'd4
    } reg_addr_e;

    localparam int          CODE_W    = 9;
    localparam logic [8:0]  INIT_CODE = 9'h100;
    localparam int          GO_BIT    = 31;

endpackage

// File: rtl/icd_cache_model.sv
module icd_cache_model #(
    parameter int WAYS  = 4,
    parameter int SETS  = 32,
    parameter int TAG_W = 20,
    parameter int LRM_W = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  freeze,
    input  logic                                  upd_en,
    input  logic [$clog2(WAYS)-1:0]               upd_way,
    input  logic [$clog2(SETS)-1:0]               upd_idx,
    input  logic [TAG_W-1:0]                      upd_tag,
    input  logic                                  upd_valid,
    input  logic [LRM_W-1:0]                      upd_lrm,
    input  logic [$clog2(WAYS)+$clog2(SETS)-1:0]  tag_sel,
    input  logic [$clog2(WAYS)+$clog2(SETS)-1:0]  valid_sel,
    input  logic [$clog2(WAYS)+$clog2(SETS)-1:0]  lrm_sel,
    output logic [TAG_W-1:0]                      tag_o,
    output logic                                  valid_o,
    output logic [LRM_W-1:0]                      lrm_o
);

    localparam int WAY_W = $clog2(WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int CNT_W = WAY_W + IDX_W;

    typedef struct packed {
        logic [WAYS-1:0][SETS-1:0][TAG_W-1:0] tag;
        logic [WAYS-1:0][SETS-1:0]            valid;
        logic [SETS-1:0][LRM_W-1:0]           lrm;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (upd_en && !freeze) begin
            arr_d.tag[upd_way][upd_idx]   = upd_tag;
            arr_d.valid[upd_way][upd_idx] = upd_valid;
            arr_d.lrm[upd_idx]            = upd_lrm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    assign tag_o   = arr_q.tag[tag_sel[CNT_W-1:IDX_W]][tag_sel[IDX_W-1:0]];
    assign valid_o = arr_q.valid[valid_sel[CNT_W-1:IDX_W]][valid_sel[IDX_W-1:0]];
    assign lrm_o   = arr_q.lrm[lrm_sel[IDX_W-1:0]];

    // R2: a frozen cache keeps every array bit
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(arr_q));

endmodule

// File: rtl/icd_walk_chan.sv
module icd_walk_chan #(
    parameter int CNT_W  = 7,
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              adv,
    output logic [CNT_W-1:0]  look_sel,
    input  logic [DATA_W-1:0] look_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [DATA_W-1:0] snap_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] snap;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        look_sel = st_d.cnt;
        if (init || adv) begin
            st_d.snap = look_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign snap_o = st_q.snap;

    // R5 / R7: each accepted read steps the counter by exactly one, wrapping
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !init) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    // R6: without its own read or an init, a window keeps its state
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !init) |=> ($stable(st_q.cnt) && $stable(st_q.snap)));

endmodule

// File: rtl/icache_dbg_walker.sv
module icache_dbg_walker #(
    parameter int NCORES = 4,
    parameter int WAYS   = 4,
    parameter int SETS   = 32,
    parameter int TAG_W  = 20,
    parameter int LRM_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORES-1:0]       core_dbg_sts,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [2:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    dbg_mode,
    input  logic                    upd_en,
    input  logic [$clog2(WAYS)-1:0] upd_way,
    input  logic [$clog2(SETS)-1:0] upd_idx,
    input  logic [TAG_W-1:0]        upd_tag,
    input  logic                    upd_valid,
    input  logic [LRM_W-1:0]        upd_lrm
);
    import icd_pkg::*;

    localparam int CNT_W = $clog2(WAYS) + $clog2(SETS);

    typedef struct packed {
        logic              dbg;
        logic [CODE_W-1:0] code;
        logic              go;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic init_cmd, rd_ok;
    logic adv_tag, adv_valid, adv_lrm;
    logic [CNT_W-1:0] sel_tag, sel_valid, sel_lrm;
    logic [CNT_W-1:0] cnt_tag, cnt_valid, cnt_lrm;
    logic [TAG_W-1:0] arr_tag, snap_tag;
    logic             arr_valid, snap_valid;
    logic [LRM_W-1:0] arr_lrm, snap_lrm;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.go = 1'b0;
        if (bus_wr && bus_addr == RA_CMD) begin
            ctl_d.code = bus_wdata[CODE_W-1:0];
            ctl_d.go   = bus_wdata[GO_BIT];
        end
        if (bus_wr && bus_addr == RA_MODE) begin
            if (bus_wdata[0])           ctl_d.dbg = 1'b1;
            else if (&core_dbg_sts)     ctl_d.dbg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign init_cmd  = ctl_q.go && (ctl_q.code == INIT_CODE);
    assign rd_ok     = bus_rd && ctl_q.dbg;
    assign adv_tag   = rd_ok && (bus_addr == RA_TAG);
    assign adv_valid = rd_ok && (bus_addr == RA_VALID);
    assign adv_lrm   = rd_ok && (bus_addr == RA_LRM);
    assign dbg_mode  = ctl_q.dbg;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CMD:   bus_rdata[CODE_W-1:0] = ctl_q.code;
            RA_MODE:  bus_rdata[0]          = ctl_q.dbg;
            RA_TAG:   if (ctl_q.dbg) bus_rdata[TAG_W-1:0] = snap_tag;
            RA_VALID: if (ctl_q.dbg) bus_rdata[0]         = snap_valid;
            RA_LRM:   if (ctl_q.dbg) bus_rdata[LRM_W-1:0] = snap_lrm;
            default:  bus_rdata = '0;
        endcase
    end

    icd_cache_model #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .LRM_W(LRM_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (ctl_q.dbg),
        .upd_en    (upd_en),
        .upd_way   (upd_way),
        .upd_idx   (upd_idx),
        .upd_tag   (upd_tag),
        .upd_valid (upd_valid),
        .upd_lrm   (upd_lrm),
        .tag_sel   (sel_tag),
        .valid_sel (sel_valid),
        .lrm_sel   (sel_lrm),
        .tag_o     (arr_tag),
        .valid_o   (arr_valid),
        .lrm_o     (arr_lrm)
    );

    icd_walk_chan #(.CNT_W(CNT_W), .DATA_W(TAG_W)) u_tag_chan (
        .clk(clk), .rst_n(rst_n), .init(init_cmd), .adv(adv_tag),
        .look_sel(sel_tag), .look_data(arr_tag), .cnt_o(cnt_tag), .snap_o(snap_tag)
    );

    icd_walk_chan #(.CNT_W(CNT_W), .DATA_W(1)) u_valid_chan (
        .clk(clk), .rst_n(rst_n), .init(init_cmd), .adv(adv_valid),
        .look_sel(sel_valid), .look_data(arr_valid), .cnt_o(cnt_valid), .snap_o(snap_valid)
    );

    icd_walk_chan #(.CNT_W(CNT_W), .DATA_W(LRM_W)) u_lrm_chan (
        .clk(clk), .rst_n(rst_n), .init(init_cmd), .adv(adv_lrm),
        .look_sel(sel_lrm), .look_data(arr_lrm), .cnt_o(cnt_lrm), .snap_o(snap_lrm)
    );

    // R1: a write of mode bit 0 = 1 always lands in debug mode
    p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_MODE && bus_wdata[0]) |=> dbg_mode);

    // R3: clear refused while any core is not yet in debug
    p_hold_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && bus_wr && bus_addr == RA_MODE && !bus_wdata[0] && !(&core_dbg_sts))
        |=> dbg_mode);

    // R4: init command zeroes every walk counter
    p_init_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd |=> (cnt_tag == '0 && cnt_valid == '0 && cnt_lrm == '0));

    // R8: window addresses read as zero outside debug
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && (bus_addr == RA_TAG || bus_addr == RA_VALID || bus_addr == RA_LRM))
        |-> (bus_rdata == '0));

    // R9: a go flag with a wrong code leaves the counters alone, and go never lasts
    p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.go && ctl_q.code != INIT_CODE && !bus_rd)
        |=> ($stable(cnt_tag) && $stable(cnt_valid) && $stable(cnt_lrm)));

    p_go_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.go && !bus_wr) |=> !ctl_q.go);

endmodule

// File: tb/icache_dbg_walker_test.sv
module icache_dbg_walker_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCORES = 4;
    localparam int WAYS = 4;
    localparam int SETS = 32;
    localparam int NENT = WAYS * SETS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NCORES-1:0] core_dbg_sts = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_mode;
    logic        upd_en = 1'b0;
    logic [1:0]  upd_way = '0;
    logic [4:0]  upd_idx = '0;
    logic [19:0] upd_tag = '0;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_lrm = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_dbg_walker uut (
        .clk(clk), .rst_n(rst_n), .core_dbg_sts(core_dbg_sts),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_mode(dbg_mode),
        .upd_en(upd_en), .upd_way(upd_way), .upd_idx(upd_idx),
        .upd_tag(upd_tag), .upd_valid(upd_valid), .upd_lrm(upd_lrm)
    );

    // behavioural reference state
    int m_tag [NENT];
    int m_val [NENT];
    int m_lrm [SETS];
    int m_cnt [3];
    int m_snap [3];
    int m_dbg, m_code, m_go;

    int checks = 0, fails = 0;
    bit done = 0;

    function automatic int lookup(int k, int c);
        if (k == 0) return m_tag[c];
        if (k == 1) return m_val[c];
        return m_lrm[c % SETS];
    endfunction

    function automatic int expect_rdata(int a);
        if (a == 0) return m_code;
        if (a == 1) return m_dbg;
        if (a >= 2 && a <= 4) return m_dbg ? m_snap[a-2] : 0;
        return 0;
    endfunction

    task automatic step(input bit wr, input bit rd, input int a, input int wd, input string req);
        int exp_r, nd, ncode, ngo;
        int ncnt [3];
        int nsnap [3];
        bus_wr = wr; bus_rd = rd; bus_addr = 3'(a); bus_wdata = 32'(wd);
        #1;
        exp_r = expect_rdata(a);
        checks++;
        if (bus_rdata !== 32'(exp_r) || dbg_mode !== 1'(m_dbg)) begin
            fails++;
            $display("FAIL %s: addr %0d rdata %h dbg %b, expected rdata %h dbg %0d",
                     req, a, bus_rdata, dbg_mode, exp_r, m_dbg);
        end
        @(posedge clk);
        nd = m_dbg; ncode = m_code; ngo = 0;
        for (int k = 0; k < 3; k++) begin ncnt[k] = m_cnt[k]; nsnap[k] = m_snap[k]; end
        if (m_go != 0 && m_code == 'h100) begin
            for (int k = 0; k < 3; k++) begin ncnt[k] = 0; nsnap[k] = lookup(k, 0); end
        end else if (rd && m_dbg != 0 && a >= 2 && a <= 4) begin
            ncnt[a-2]  = (m_cnt[a-2] + 1) % NENT;
            nsnap[a-2] = lookup(a-2, ncnt[a-2]);
        end
        if (wr && a == 0) begin ncode = wd & 'h1FF; ngo = (wd >>> 31) & 1; end
        if (wr && a == 1) begin
            if (wd & 1) nd = 1;
            else if (&core_dbg_sts) nd = 0;
        end
        if (upd_en && m_dbg == 0) begin
            m_tag[upd_way*SETS + upd_idx] = int'(upd_tag);
            m_val[upd_way*SETS + upd_idx] = int'(upd_valid);
            m_lrm[upd_idx] = int'(upd_lrm);
        end
        m_dbg = nd; m_code = ncode; m_go = ngo;
        for (int k = 0; k < 3; k++) begin m_cnt[k] = ncnt[k]; m_snap[k] = nsnap[k]; end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 1'b0, 1, 0, req);
    endtask

    task automatic init_walk(input string req);
        step(1, 0, 0, 'h100, req);
        step(1, 0, 0, 'h8000_0100, req);
        idle(1, req);
    endtask

    task automatic fill(input int salt);
        for (int w = 0; w < WAYS; w++) begin
            for (int i = 0; i < SETS; i++) begin
                upd_en = 1; upd_way = 2'(w); upd_idx = 5'(i);
                upd_tag = 20'((w * 40503 + i * 2654 + 17 + salt) & 'hFFFFF);
                upd_valid = 1'(((w + i + salt) % 3) != 0);
                upd_lrm = 3'((i * 5 + w + salt) & 7);
                step(0, 0, 1, 0, "R2");
            end
        end
        upd_en = 0;
    endtask

    initial begin
        foreach (m_tag[i]) begin m_tag[i] = 0; m_val[i] = 0; end
        foreach (m_lrm[i]) m_lrm[i] = 0;
        for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; m_snap[k] = 0; end
        m_dbg = 0; m_code = 0; m_go = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11: reset state across all addresses
        for (int a = 0; a < 5; a++) step(0, 0, a, 0, "R11");
        // R8: window reads outside debug return zero, no advance
        fill(0);
        for (int a = 2; a < 5; a++) step(0, 1, a, 0, "R8");
        // R1: enter debug mode
        step(1, 0, 1, 1, "R1");
        step(0, 0, 1, 0, "R1");
        // R2: update attempts while frozen
        upd_en = 1; upd_way = 0; upd_idx = 0; upd_tag = 20'hABCDE; upd_valid = 1; upd_lrm = 3'd7;
        step(0, 0, 1, 0, "R2");
        upd_en = 0;
        // R4: init command, then walk
        init_walk("R4");
        step(0, 0, 0, 0, "R4");
        // R5, R7, R10: back-to-back tag walk through full wrap
        for (int n = 0; n < NENT + 3; n++) step(0, 1, 2, 0, "R7");
        // R6: valid and replacement windows untouched by tag reads, then interleaved
        for (int n = 0; n < 40; n++) begin
            step(0, 1, 3, 0, "R6");
            step(0, 1, 4, 0, "R10");
            step(0, 0, 2, 0, "R6");
        end
        // R9: wrong code with go
        step(1, 0, 0, 'h8000_00FF, "R9");
        for (int a = 2; a < 5; a++) step(0, 0, a, 0, "R9");
        step(0, 1, 2, 0, "R5");
        // R3: clear refused with incomplete core status
        core_dbg_sts = 4'b0111;
        step(1, 0, 1, 0, "R3");
        step(0, 1, 3, 0, "R3");
        core_dbg_sts = 4'b1111;
        step(1, 0, 1, 0, "R3");
        step(0, 1, 2, 0, "R8");
        step(0, 0, 3, 0, "R8");
        // updates take effect again, re-enter and walk
        fill(5);
        step(1, 0, 1, 1, "R1");
        init_walk("R4");
        for (int n = 0; n < 70; n++) step(0, 1, 2 + (n % 3), 0, "R5");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule